// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers a vector of interrupt source lines into a status word, filters that word through a software-programmed enable mask, and drives a single level-sensitive interrupt request toward a processor. The request is high whenever at least one enabled status bit is set. Software reaches the block through a word-wide register port that has a write strobe, a word offset and write data. Read data is returned combinationally for the offset currently on the address lines.

A high source line keeps its status bit set. A source line that falls clears its bit. Software can clear chosen bits by writing ones to them, or it can load a whole status word through a second offset. It can also program the enable mask and read back the masked status. Where a source event and a software write touch the same bit in the same cycle, the source event decides the result. The request output is a register, updated on the same clock edge as the status and enable registers.

Top module: `irqagg`

## Requirements
- R1: Source line i maps to status bit i. A source line sampled high leaves its status bit at 1 after the clock edge, even when a write in that same cycle clears that bit or loads a 0 into it.
- R2: A source line sampled low that was sampled high at the previous edge (a falling line) leaves its status bit at 0 after the edge, even when a write in that same cycle loads a 1 into it.
- R3: A write to offset 0 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged. A read of offset 0 returns the status word.
- R4: A write to offset 1 replaces the status word with the write data, subject to R1 and R2. A read of offset 1 returns the status word.
- R5: A write to offset 2 loads the enable mask from the write data. A read of offset 2 returns the enable mask.
- R6: A read of offset 3 returns status AND enable. A write to offset 3 changes neither status nor enable.
- R7: Offsets 4 to 7 read as zero. Writes to those offsets change neither status nor enable.
- R8: irq_o is 1 exactly when status AND enable is nonzero. It is registered, so it changes at the same clock edge that updates status or enable, which is one cycle after the source or write that caused the change is presented.
- R9: When rst is sampled high at a clock edge, status, enable and irq_o are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 32 | Interrupt source lines, one per status bit |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 3 | Word offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the offset on addr_i |
| irq_o | output | 1 | Level interrupt request to the processor |

## Verification
The properties assume that the source lines and the bus inputs are synchronous to clk and settle between edges. They also assume that a write lasts one cycle, with the offset and data valid while the strobe is high. The check that an ignored write leaves status untouched relies on the sources holding steady across that edge and on the edge before it not being a reset edge. The bench therefore changes every input only at the falling clock edge. It holds the source lines constant through each ignored-write step and leaves idle cycles between steps, so every source change is settled before the next write arrives.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef enum logic [1:0] {
    OFS_STATUS = 2'd0,
    OFS_SETALL = 2'd1,
    OFS_ENABLE = 2'd2,
    OFS_MASKED = 2'd3
  } ofs_e;

  function automatic ofs_e low_ofs(input logic [1:0] a);
    return ofs_e'(a);
  endfunction
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] fall_o
);
  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= src_i;
  end

  assign fall_o = prev_q & ~src_i;
endmodule

// File: rtl/irqagg_bus.sv
module irqagg_bus
  import irqagg_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  status_q,
  input  logic [N_SRC-1:0]  enable_q,
  output logic              wr_clr_o,
  output logic              wr_set_o,
  output logic              wr_enb_o,
  output logic [N_SRC-1:0]  rdata_o
);
  logic mapped;
  ofs_e ofs;

  generate
    if (ADDR_W > 2) begin : g_upper
      assign mapped = (addr_i[ADDR_W-1:2] == '0);
    end else begin : g_exact
      assign mapped = 1'b1;
    end
  endgenerate

  assign ofs      = low_ofs(addr_i[1:0]);
  assign wr_clr_o = wr_en_i && mapped && (ofs == OFS_STATUS);
  assign wr_set_o = wr_en_i && mapped && (ofs == OFS_SETALL);
  assign wr_enb_o = wr_en_i && mapped && (ofs == OFS_ENABLE);

  always_comb begin
    rdata_o = '0;
    if (mapped) begin
      case (ofs)
        OFS_STATUS: rdata_o = status_q;
        OFS_SETALL: rdata_o = status_q;
        OFS_ENABLE: rdata_o = enable_q;
        OFS_MASKED: rdata_o = status_q & enable_q;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] fall_i,
  input  logic             wr_clr_i,
  input  logic             wr_set_i,
  input  logic             wr_enb_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] status_q,
  output logic [N_SRC-1:0] enable_q,
  output logic             irq_q
);
  function automatic logic [N_SRC-1:0] next_status(
    input logic [N_SRC-1:0] cur,
    input logic             clr,
    input logic             set,
    input logic [N_SRC-1:0] wd,
    input logic [N_SRC-1:0] src,
    input logic [N_SRC-1:0] fall
  );
    logic [N_SRC-1:0] base;
    base = set ? wd : (clr ? (cur & ~wd) : cur);
    return (base | src) & ~fall;
  endfunction

  function automatic logic any_pending(
    input logic [N_SRC-1:0] st,
    input logic [N_SRC-1:0] en
  );
    return |(st & en);
  endfunction

  logic [N_SRC-1:0] status_nxt;
  logic [N_SRC-1:0] enable_nxt;

  assign status_nxt = next_status(status_q, wr_clr_i, wr_set_i, wdata_i, src_i, fall_i);
  assign enable_nxt = wr_enb_i ? wdata_i : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      enable_q <= enable_nxt;
      irq_q    <= any_pending(status_nxt, enable_nxt);
    end
  end
endmodule

// File: rtl/irqagg.sv
module irqagg #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] fall_w;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic             wr_clr_w;
  logic             wr_set_w;
  logic             wr_enb_w;

  irqagg_edge #(.N_SRC(N_SRC)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_i),
    .fall_o (fall_w)
  );

  irqagg_bus #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_bus (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .status_q (status_q),
    .enable_q (enable_q),
    .wr_clr_o (wr_clr_w),
    .wr_set_o (wr_set_w),
    .wr_enb_o (wr_enb_w),
    .rdata_o  (rdata_o)
  );

  irqagg_regs #(.N_SRC(N_SRC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .fall_i   (fall_w),
    .wr_clr_i (wr_clr_w),
    .wr_set_i (wr_set_w),
    .wr_enb_i (wr_enb_w),
    .wdata_i  (wdata_i),
    .status_q (status_q),
    .enable_q (enable_q),
    .irq_q    (irq_o)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  src_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic [N_SRC-1:0]  fall_w
);
  logic ign_wr;
  assign ign_wr = wr_en_i && (addr_i >= ADDR_W'(3));

  assert_src_sets_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(src_i)) == $past(src_i)));

  assert_fall_clears_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(fall_w)) == '0));

  assert_enable_load_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(2)) |=> (enable_q == $past(wdata_i)));

  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (rst)
    (ign_wr && $stable(src_i) && !$past(rst)) |=> ($stable(status_q) && $stable(enable_q)));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(status_q & enable_q)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (status_q == '0 && enable_q == '0 && !irq_o));
endmodule

bind irqagg irqagg_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_i    (src_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .status_q (status_q),
  .enable_q (enable_q),
  .fall_w   (fall_w)
);

// File: tb/tb_irqagg.sv
module tb_irqagg;
  localparam int N  = 32;
  localparam int AW = 3;
  localparam int NSTEP = 15;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  src;
  logic          wr;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata;
  logic [N-1:0]  rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irqagg #(.N_SRC(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [N-1:0] T_SRC [NSTEP] = '{
    32'h5, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h100, 32'h100, 32'h100, 32'h100, 32'h100, 32'h100, 32'h0};
  localparam logic T_WR [NSTEP] = '{
    1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [AW-1:0] T_ADDR [NSTEP] = '{
    3'd0, 3'd2, 3'd2, 3'd0, 3'd1, 3'd2, 3'd0, 3'd0,
    3'd0, 3'd3, 3'd5, 3'd0, 3'd1, 3'd2, 3'd1};
  localparam logic [N-1:0] T_WD [NSTEP] = '{
    32'h0, 32'h4, 32'h1, 32'h0, 32'h8000_0010, 32'h8000_0000, 32'h10, 32'h8000_0000,
    32'h100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h100};
  localparam logic [AW-1:0] T_RD [NSTEP] = '{
    3'd0, 3'd3, 3'd3, 3'd0, 3'd1, 3'd2, 3'd0, 3'd0,
    3'd0, 3'd2, 3'd0, 3'd6, 3'd0, 3'd3, 3'd0};
  localparam logic [N-1:0] T_EXP [NSTEP] = '{
    32'h5, 32'h0, 32'h1, 32'h0, 32'h8000_0010, 32'h8000_0000, 32'h8000_0000, 32'h0,
    32'h100, 32'h8000_0000, 32'h100, 32'h0, 32'h100, 32'h100, 32'h0};
  localparam logic T_IRQ [NSTEP] = '{
    1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam string T_TAG [NSTEP] = '{
    "R1 R3", "R2 R5 R6", "R5 R6 R8", "R2 R8", "R4", "R5 R8", "R3 R8", "R3 R8",
    "R1 R3", "R6", "R7", "R7", "R1 R4", "R6 R8", "R2 R4"};

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [AW-1:0] a, input string tag, input logic [N-1:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    rst = 1'b1; src = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    look(3'd0, "R9 status after reset", 32'h0);
    look(3'd2, "R9 enable after reset", 32'h0);
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      src = T_SRC[i]; wr = T_WR[i]; addr = T_ADDR[i]; wdata = T_WD[i];
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; addr = T_RD[i];
      #1;
      chk($sformatf("%s step %0d rdata", T_TAG[i], i), rdata, T_EXP[i]);
      chk($sformatf("%s step %0d irq", T_TAG[i], i), {31'b0, irq}, {31'b0, T_IRQ[i]});
    end

    // R8: output is registered, no change before the edge
    @(negedge clk);
    wr = 1'b1; addr = 3'd2; wdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; src = 32'h1;
    #2;
    chk("R8 irq before edge", {31'b0, irq}, 32'h0);
    @(posedge clk);
    #1;
    chk("R8 irq after edge", {31'b0, irq}, 32'h1);

    // R9: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; src = '0;
    look(3'd0, "R9 status after mid reset", 32'h0);
    look(3'd2, "R9 enable after mid reset", 32'h0);
    chk("R9 irq after mid reset", {31'b0, irq}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule